// File: doc/BRIEF.md
# Spin-Wait Loop Exit Detector

This block watches a pulse that marks each retired spin-wait hint instruction and stamps every such pulse with the value of a free-running cycle counter. A pause that arrives within the gap threshold of the previous pause continues the current spin loop. A pause that arrives later than that opens a new loop. When a continuing pause finds that the loop has lasted longer than the window threshold, counted from the loop's first pause, the block raises a one-cycle exit request. The surrounding control logic uses that request to take the spinning context off the core.

The two thresholds sit in registers loaded through a plain address/data write port. One bit of a control word, supplied by the surrounding logic, switches the detector on. The pause and exit signals are single-cycle event strobes and have no back-pressure. A pause is always taken in the cycle in which it is presented, and the exit request cannot be stalled.

Top module: `pause_loop_exit`

## Requirements
- R1: After reset `exit_o` is low and both thresholds hold zero. Because of that, pauses arriving one per cycle right after reset never raise an exit.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 0x4020 loads the gap threshold. A write to 0x4022 loads the window threshold. Writes to any other address change neither threshold.
- R3: A pause whose distance in cycles from the previous pause is greater than the gap starts a new loop and raises no exit.
- R4: A pause that continues a loop, whose distance from the loop's first pause is greater than the window, raises `exit_o` for exactly one cycle. The pulse is visible in the cycle after the pause is sampled.
- R5: A continuing pause whose distance from the loop's first pause equals the window raises no exit.
- R6: A pause whose distance from the previous pause equals the gap continues the loop.
- R7: The first pause after an exit always starts a new loop and raises no exit.
- R8: The detector is enabled only while bit 10 (mask 0x400) of `ctrl_word` is set. While that bit is clear, pauses are ignored and `exit_o` stays low, and other bits of `ctrl_word` have no effect. The first pause after the bit is set starts a new loop.
- R9: Threshold writes take effect while the detector is disabled.
- R10: Distances are taken modulo the counter width, so loop tracking works the same way across counter wraparound.
- R11: A window of zero makes the second pause of any loop raise an exit. A gap of zero makes every pause start a new loop, so no exit is ever raised.
- R12: Every pause moves the last-pause time, so a chain of pauses each within the gap stays in one loop even after its total length passes the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_addr | input | ADDR_W | Threshold write address |
| cfg_wdata | input | CNT_W | Threshold write data |
| ctrl_word | input | CTRL_W | Control word; bit EN_BIT enables detection |
| pause_i | input | 1 | One-cycle strobe per retired spin-wait hint |
| exit_o | output | 1 | One-cycle exit request |

## Verification
The bench builds the block with an 8-bit counter and 8-bit thresholds. With those widths the counter wraps every 256 cycles, so a short run of evenly spaced pauses crosses the wrap several times and exercises the modular distance logic. Small thresholds keep every boundary within a few cycles: a distance equal to the gap, an elapsed time equal to the window, and the zero settings. The other parameters keep their default values, so the register addresses and the enable bit position are the ones stated in the requirements.

// File: rtl/ple_pkg.sv
package ple_pkg;
  localparam int unsigned PLE_ADDR_W   = 16;
  localparam int unsigned PLE_GAP_ADDR = 16'h4020;
  localparam int unsigned PLE_WIN_ADDR = 16'h4022;
  localparam int unsigned PLE_EN_BIT   = 10;

  typedef enum logic [1:0] {
    CFG_NONE = 2'd0,
    CFG_GAP  = 2'd1,
    CFG_WIN  = 2'd2
  } cfg_target_e;
endpackage

// File: rtl/ple_cycle_counter.sv
module ple_cycle_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] now_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_o <= '0;
    else        now_o <= now_o + ONE;
  end

  p_count_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now_o == $past(now_o) + ONE);
endmodule

// File: rtl/ple_threshold_regs.sv
module ple_threshold_regs
  import ple_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = PLE_ADDR_W,
  parameter int unsigned GAP_ADDR = PLE_GAP_ADDR,
  parameter int unsigned WIN_ADDR = PLE_WIN_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  data_i,
  output logic [CNT_W-1:0]  gap_o,
  output logic [CNT_W-1:0]  win_o
);
  localparam logic [ADDR_W-1:0] GAP_A = ADDR_W'(GAP_ADDR);
  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_ADDR);

  cfg_target_e target;

  always_comb begin
    target = CFG_NONE;
    if (we_i) begin
      if (addr_i == GAP_A)      target = CFG_GAP;
      else if (addr_i == WIN_A) target = CFG_WIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_o <= '0;
      win_o <= '0;
    end else begin
      case (target)
        CFG_GAP: gap_o <= data_i;
        CFG_WIN: win_o <= data_i;
        default: ;
      endcase
    end
  end

  p_gap_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == GAP_A) |=> gap_o == $past(data_i));
  p_win_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == WIN_A) |=> win_o == $past(data_i));
  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i || (addr_i != GAP_A && addr_i != WIN_A)) |=> ($stable(gap_o) && $stable(win_o)));
endmodule

// File: rtl/ple_loop_tracker.sv
module ple_loop_tracker #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic [CNT_W-1:0] now_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] win_i,
  output logic             exit_o
);
  logic [CNT_W-1:0] last_ts;
  logic [CNT_W-1:0] start_ts;
  logic             in_loop;
  logic [CNT_W-1:0] since_last;
  logic [CNT_W-1:0] since_start;
  logic             opens_loop;
  logic             too_long;

  // modular distances: correct across counter wrap
  assign since_last  = now_i - last_ts;
  assign since_start = now_i - start_ts;
  assign opens_loop  = !in_loop || (since_last > gap_i);
  assign too_long    = since_start > win_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ts  <= '0;
      start_ts <= '0;
      in_loop  <= 1'b0;
      exit_o   <= 1'b0;
    end else if (!en_i) begin
      in_loop <= 1'b0;
      exit_o  <= 1'b0;
    end else begin
      exit_o <= 1'b0;
      if (pause_i) begin
        last_ts <= now_i;
        if (opens_loop) begin
          start_ts <= now_i;
          in_loop  <= 1'b1;
        end else if (too_long) begin
          exit_o  <= 1'b1;
          in_loop <= 1'b0;
        end
      end
    end
  end

  p_exit_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |=> !exit_o);
  p_exit_from_pause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> $past(pause_i && en_i));
  p_new_loop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pause_i && !in_loop) |=> !exit_o);
  p_exit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> !in_loop);
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!exit_o && !in_loop));
endmodule

// File: rtl/pause_loop_exit.sv
module pause_loop_exit
  import ple_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned ADDR_W   = PLE_ADDR_W,
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned EN_BIT   = PLE_EN_BIT,
  parameter int unsigned GAP_ADDR = PLE_GAP_ADDR,
  parameter int unsigned WIN_ADDR = PLE_WIN_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              pause_i,
  output logic              exit_o
);
  logic [CNT_W-1:0] now;
  logic [CNT_W-1:0] gap;
  logic [CNT_W-1:0] win;
  logic             en;

  assign en = ctrl_word[EN_BIT];

  ple_cycle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now)
  );

  ple_threshold_regs #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .GAP_ADDR (GAP_ADDR),
    .WIN_ADDR (WIN_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .addr_i (cfg_addr),
    .data_i (cfg_wdata),
    .gap_o  (gap),
    .win_o  (win)
  );

  ple_loop_tracker #(.CNT_W(CNT_W)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .pause_i (pause_i),
    .now_i   (now),
    .gap_i   (gap),
    .win_i   (win),
    .exit_o  (exit_o)
  );

  p_no_exit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_i |=> !exit_o);
  p_no_exit_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[EN_BIT] |=> !exit_o);
endmodule

// File: tb/pause_loop_exit_test.sv
`timescale 1ns/1ps
module pause_loop_exit_test;
  localparam int CW = 8;
  localparam int AW = 16;
  localparam logic [31:0] EN_MASK = 32'h0000_0400;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [31:0]   ctrl_word = '0;
  logic          pause_i = 1'b0;
  logic          exit_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pause_loop_exit #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl_word(ctrl_word), .pause_i(pause_i), .exit_o(exit_o)
  );

  // behavioural reference: absolute cycle times, a queue of the loop's pause times
  int m_cyc, m_gap, m_win;
  int loopq[$];
  bit m_exit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 0; m_gap = 0; m_win = 0; m_exit = 0;
      loopq.delete();
    end else begin
      bit nx;
      nx = 0;
      if (!ctrl_word[10]) loopq.delete();
      else if (pause_i) begin
        if (loopq.size() == 0 || (m_cyc - loopq[$]) > m_gap) begin
          loopq.delete();
          loopq.push_back(m_cyc);
        end else if ((m_cyc - loopq[0]) > m_win) begin
          nx = 1;
          loopq.delete();
        end else loopq.push_back(m_cyc);
      end
      if (cfg_we && cfg_addr == 16'h4020) m_gap = int'(cfg_wdata);
      if (cfg_we && cfg_addr == 16'h4022) m_win = int'(cfg_wdata);
      m_exit = nx;
      m_cyc++;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: exit_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) check("R4 model compare", exit_o, m_exit);

  task automatic cfg_write(input logic [AW-1:0] a, input logic [CW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic restart();
    ctrl_word = '0;
    @(negedge clk);
    ctrl_word = EN_MASK;
  endtask

  task automatic do_pause(input int spacing, output logic ex);
    repeat (spacing - 1) @(negedge clk);
    pause_i = 1'b1;
    @(negedge clk);
    pause_i = 1'b0;
    ex = exit_o;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ex;
    repeat (3) @(negedge clk);
    check("R1 reset exit low", exit_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", exit_o, 1'b0);
    ctrl_word = EN_MASK;
    for (int k = 1; k <= 8; k++) begin
      do_pause(1, ex);
      check("R1 zero thresholds after reset", ex, 1'b0);
    end

    // R4 R5 R7 R12: gap 10 window 20, spacing 5
    cfg_write(16'h4020, 8'd10);
    cfg_write(16'h4022, 8'd20);
    restart();
    for (int k = 1; k <= 6; k++) begin
      do_pause(5, ex);
      check(k == 5 ? "R5 elapsed equals window" : (k == 6 ? "R4 exit raised" : "R12 chain stays"),
            ex, k == 6);
    end
    @(negedge clk);
    check("R4 pulse single cycle", exit_o, 1'b0);
    do_pause(5, ex);
    check("R7 new loop after exit", ex, 1'b0);
    do_pause(5, ex);
    check("R7 second pause of new loop", ex, 1'b0);

    // R6: spacing equal to gap continues the loop
    cfg_write(16'h4020, 8'd4);
    cfg_write(16'h4022, 8'd100);
    restart();
    for (int k = 1; k <= 30; k++) begin
      do_pause(4, ex);
      check("R6 spacing equal gap", ex, k == 27);
    end
    // R3: spacing above gap always opens a new loop
    restart();
    for (int k = 1; k <= 30; k++) begin
      do_pause(5, ex);
      check("R3 spacing above gap", ex, 1'b0);
    end

    // R10: wraparound of the 8-bit counter
    cfg_write(16'h4020, 8'd10);
    cfg_write(16'h4022, 8'd30);
    restart();
    for (int k = 1; k <= 40; k++) begin
      do_pause(8, ex);
      check("R10 across wrap", ex, (k % 5) == 0);
    end

    // R11: zero window, then zero gap
    cfg_write(16'h4020, 8'd5);
    cfg_write(16'h4022, 8'd0);
    restart();
    do_pause(1, ex);
    check("R11 zero window first pause", ex, 1'b0);
    do_pause(1, ex);
    check("R11 zero window second pause", ex, 1'b1);
    cfg_write(16'h4020, 8'd0);
    restart();
    for (int k = 1; k <= 10; k++) begin
      do_pause(1, ex);
      check("R11 zero gap", ex, 1'b0);
    end

    // R8: disabled, and other control bits do nothing
    cfg_write(16'h4020, 8'd5);
    ctrl_word = '0;
    for (int k = 1; k <= 10; k++) begin
      do_pause(1, ex);
      check("R8 disabled ignores pauses", ex, 1'b0);
    end
    ctrl_word = 32'hFFFF_FBFF;
    for (int k = 1; k <= 10; k++) begin
      do_pause(1, ex);
      check("R8 other bits no effect", ex, 1'b0);
    end

    // R9: writes while disabled take effect
    ctrl_word = '0;
    cfg_write(16'h4020, 8'd50);
    cfg_write(16'h4022, 8'd3);
    ctrl_word = EN_MASK;
    for (int k = 1; k <= 3; k++) begin
      do_pause(2, ex);
      check("R9 write while disabled", ex, k == 3);
    end

    // R2: other addresses leave thresholds alone
    cfg_write(16'h4020, 8'd10);
    cfg_write(16'h4022, 8'd50);
    cfg_write(16'h4024, 8'd0);
    cfg_write(16'h4021, 8'd0);
    cfg_write(16'h0022, 8'd0);
    restart();
    for (int k = 1; k <= 5; k++) begin
      do_pause(2, ex);
      check("R2 unmapped address ignored", ex, 1'b0);
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule